// File: doc/BRIEF.md
# Two-Way Data Cache Controller with Lockable Ways

This block is the controller of a small two-way set-associative data cache. The set is selected by untranslated index bits. The tag that is compared arrives in the same cycle from a separate translation path, so the cache is indexed before translation and tagged after it. Each access carries a page attribute that chooses how a store is handled. Write-through stores go to memory at once. Write-back stores only mark the line dirty.

On a miss the controller first writes back a dirty victim, then issues one read request for the missing line. The memory returns the line starting with the requested doubleword and wrapping around, and the requester is answered as soon as that first doubleword lands. Software can lock either way of any set, and a locked way is never replaced. When both ways of a set are locked, a miss in that set goes to memory without allocating a line.

Top module: `dcache_2way`

## Requirements
- R1: After reset, no line is valid, no way is locked, every replacement bit is 0, `reqReady` is 1 and `rspValid` and `memReqValid` are 0.
- R2: A read that hits is answered one cycle after it is accepted, with `rspHit`=1 and the stored doubleword on `rspData`.
- R3: The lookup uses `reqIdx` to select the set and compares `reqTag` against both ways in the acceptance cycle. A line with the same tag in another set does not hit.
- R4: A store with `reqWt`=1 drives one memory write beat one cycle after acceptance, with `memReqAddr` = {tag, index, offset} (offset in the low bits) and the store data, and answers in that same cycle. A hit also updates the cached word. A miss allocates nothing.
- R5: A store with `reqWt`=0 that hits updates the cached word, marks the line dirty, answers one cycle later and makes no memory traffic.
- R6: A store with `reqWt`=0 that misses in a set with an unlocked way refills the line, merges the store data into the requested word and leaves the line dirty.
- R7: With no lock in a set, the victim is the way named by that set's replacement bit. Every hit and every fill of way w sets the bit to the other way.
- R8: A pulse on `lockWe` loads `lockWays` into the lock bits of set `lockIdx`, where bit w locks way w. A locked way is never replaced while the other way is unlocked.
- R9: When both ways of a set are locked, a read miss returns the memory word without allocating, and a store miss with either attribute goes to memory as one write beat.
- R10: Before refilling over a dirty victim, the controller writes the victim line back in WORDS beats at offsets 0 upward, and only then issues the read request.
- R11: A refill issues one read request at the missed address. The memory returns WORDS beats in wrap order from that offset. The response, with `rspHit`=0 and `rspData`=0 for stores, comes one cycle after the first beat.
- R12: `reqReady` stays 0 from the acceptance of an allocating or non-allocating read miss until the cycle after the last refill beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request |
| reqReady | output | 1 | Controller idle and able to accept |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqWt | input | 1 | Page attribute: 1 = write-through, 0 = write-back |
| reqIdx | input | IDX_W | Set index from the untranslated address |
| reqTag | input | TAG_W | Tag from the translation path |
| reqOff | input | OFF_W | Doubleword offset within the line |
| reqData | input | DATA_W | Store data |
| rspValid | output | 1 | Response strobe |
| rspHit | output | 1 | Response came from a hit |
| rspData | output | DATA_W | Load data (0 for stores) |
| lockWe | input | 1 | Load lock bits of one set |
| lockIdx | input | IDX_W | Set whose lock bits are loaded |
| lockWays | input | 2 | New lock bits, bit w locks way w |
| memReqValid | output | 1 | Memory request beat |
| memReqWrite | output | 1 | 1 = write beat, 0 = line read |
| memReqAddr | output | ADDR_W | Doubleword address {tag, index, offset} |
| memReqData | output | DATA_W | Write beat data |
| memRspValid | input | 1 | Refill beat |
| memRspData | input | DATA_W | Refill data |

## Verification
Hits and write-through or non-allocating stores answer exactly one cycle after acceptance. Any store to memory appears on the memory port in that same cycle. A refill answer comes one cycle after the first returned beat. Write-back beats precede the read request by one cycle each. The bench drives and samples on the falling edge, so each one-cycle result is read at the first falling edge after the accepting rising edge. Refill answers are awaited and then checked to arrive while beats of the line are still outstanding. Every memory write beat is compared, in order, against a queue that a behavioural model fills when it issues the access.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  typedef struct packed {
    logic touch;      // set replacement bit away from way
    logic writeWord;  // write one doubleword
    logic fromMem;    // word source: memory beat (1) or store data (0)
    logic install;    // set tag, valid, dirty=markDirty
    logic markDirty;
    logic way;
  } ctlStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WBACK, ST_FREQ, ST_FILL} ctlState_t;
endpackage

// File: rtl/cache2w_datapath.sv
module cache2w_datapath import cache2w_pkg::*; #(
  parameter int SETS   = 4,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  lookIdx,
  input  logic [TAG_W-1:0]  lookTag,
  input  logic [OFF_W-1:0]  wordOff,
  input  logic              rdWay,
  input  logic [OFF_W-1:0]  rdOff,
  input  logic [DATA_W-1:0] cpuData,
  input  logic [DATA_W-1:0] memData,
  input  ctlStrobe_t        stb,
  input  logic              lockWe,
  input  logic [IDX_W-1:0]  lockIdx,
  input  logic [1:0]        lockWays,
  output logic              hit,
  output logic              hitWay,
  output logic              victimWay,
  output logic              bothLocked,
  output logic              victimDirty,
  output logic [TAG_W-1:0]  victimTag,
  output logic [DATA_W-1:0] rdData
);
  logic [SETS-1:0][1:0] validQ, dirtyQ, lockQ;
  logic [SETS-1:0]      lruQ;
  logic [TAG_W-1:0]     tagQ  [2][SETS];
  logic [DATA_W-1:0]    dataQ [2][SETS][WORDS];
  logic [1:0]           match;
  logic [1:0]           lk;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign match[w] = validQ[lookIdx][w] && (tagQ[w][lookIdx] == lookTag);
  end

  always_comb begin
    hit         = |match;
    hitWay      = match[1];
    lk          = lockQ[lookIdx];
    bothLocked  = &lk;
    victimWay   = lk[0] ? 1'b1 : (lk[1] ? 1'b0 : lruQ[lookIdx]);
    victimDirty = validQ[lookIdx][victimWay] & dirtyQ[lookIdx][victimWay];
    victimTag   = tagQ[victimWay][lookIdx];
    rdData      = dataQ[rdWay][lookIdx][rdOff];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
      lockQ  <= '0;
      lruQ   <= '0;
    end else begin
      if (stb.touch) lruQ[lookIdx] <= ~stb.way;
      if (stb.install) begin
        validQ[lookIdx][stb.way] <= 1'b1;
        dirtyQ[lookIdx][stb.way] <= stb.markDirty;
      end else if (stb.markDirty) begin
        dirtyQ[lookIdx][stb.way] <= 1'b1;
      end
      if (lockWe) lockQ[lockIdx] <= lockWays;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.install) tagQ[stb.way][lookIdx] <= lookTag;
    if (stb.writeWord)
      dataQ[stb.way][lookIdx][wordOff] <= stb.fromMem ? memData : cpuData;
  end
endmodule

// File: rtl/cache2w_control.sv
module cache2w_control import cache2w_pkg::*; #(
  parameter int SETS   = 4,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 64,
  localparam int IDX_W  = $clog2(SETS),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int ADDR_W = TAG_W + IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqWt,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [OFF_W-1:0]  reqOff,
  input  logic [DATA_W-1:0] reqData,
  output logic              rspValid,
  output logic              rspHit,
  output logic [DATA_W-1:0] rspData,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqData,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  input  logic              hit,
  input  logic              hitWay,
  input  logic              victimWay,
  input  logic              bothLocked,
  input  logic              victimDirty,
  input  logic [TAG_W-1:0]  victimTag,
  input  logic [DATA_W-1:0] rdData,
  output logic [IDX_W-1:0]  lookIdx,
  output logic [TAG_W-1:0]  lookTag,
  output logic [OFF_W-1:0]  wordOff,
  output logic              rdWay,
  output logic [OFF_W-1:0]  rdOff,
  output logic [DATA_W-1:0] cpuData,
  output ctlStrobe_t        stb
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(WORDS - 1);

  ctlState_t         state;
  logic [IDX_W-1:0]  sIdx;
  logic [TAG_W-1:0]  sTag, sVTag;
  logic [OFF_W-1:0]  sOff, cnt, fillOff;
  logic [DATA_W-1:0] sData;
  logic              sWr, sWay, sAlloc;
  logic              idle, accept, firstBeat;

  always_comb begin
    idle      = (state == ST_IDLE);
    reqReady  = idle;
    accept    = idle & reqValid;
    fillOff   = sOff + cnt;
    lookIdx   = idle ? reqIdx  : sIdx;
    lookTag   = idle ? reqTag  : sTag;
    wordOff   = idle ? reqOff  : fillOff;
    rdWay     = idle ? hitWay  : sWay;
    rdOff     = idle ? reqOff  : cnt;
    cpuData   = idle ? reqData : sData;
    firstBeat = (state == ST_FILL) && memRspValid && (cnt == '0);
    stb = '0;
    if (accept && hit) begin
      stb.touch     = 1'b1;
      stb.way       = hitWay;
      stb.writeWord = reqWrite;
      stb.markDirty = reqWrite & ~reqWt;
    end else if ((state == ST_FILL) && memRspValid && sAlloc) begin
      stb.way       = sWay;
      stb.writeWord = 1'b1;
      stb.fromMem   = !(firstBeat && sWr);
      stb.install   = firstBeat;
      stb.touch     = firstBeat;
      stb.markDirty = firstBeat & sWr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      rspValid    <= 1'b0;
      rspHit      <= 1'b0;
      rspData     <= '0;
      memReqValid <= 1'b0;
      memReqWrite <= 1'b0;
      memReqAddr  <= '0;
      memReqData  <= '0;
      sIdx <= '0; sTag <= '0; sVTag <= '0; sOff <= '0; cnt <= '0;
      sData <= '0; sWr <= 1'b0; sWay <= 1'b0; sAlloc <= 1'b0;
    end else begin
      rspValid    <= 1'b0;
      memReqValid <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          if (hit || (reqWrite && (reqWt || bothLocked))) begin
            rspValid <= 1'b1;
            rspHit   <= hit;
            rspData  <= reqWrite ? '0 : rdData;
            if (reqWrite && (reqWt || !hit)) begin
              memReqValid <= 1'b1;
              memReqWrite <= 1'b1;
              memReqAddr  <= {reqTag, reqIdx, reqOff};
              memReqData  <= reqData;
            end
          end else begin
            sIdx   <= reqIdx;  sTag  <= reqTag;   sOff <= reqOff;
            sData  <= reqData; sWr   <= reqWrite;
            sWay   <= victimWay; sVTag <= victimTag;
            sAlloc <= !bothLocked;
            cnt    <= '0;
            state  <= (!bothLocked && victimDirty) ? ST_WBACK : ST_FREQ;
          end
        end
        ST_WBACK: begin
          memReqValid <= 1'b1;
          memReqWrite <= 1'b1;
          memReqAddr  <= {sVTag, sIdx, cnt};
          memReqData  <= rdData;
          cnt         <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_FREQ;
        end
        ST_FREQ: begin
          memReqValid <= 1'b1;
          memReqWrite <= 1'b0;
          memReqAddr  <= {sTag, sIdx, sOff};
          memReqData  <= '0;
          cnt         <= '0;
          state       <= ST_FILL;
        end
        ST_FILL: if (memRspValid) begin
          if (cnt == '0) begin
            rspValid <= 1'b1;
            rspHit   <= 1'b0;
            rspData  <= sWr ? '0 : memRspData;
          end
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcache_2way.sv
module dcache_2way import cache2w_pkg::*; #(
  parameter int SETS   = 4,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 64,
  localparam int IDX_W  = $clog2(SETS),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int ADDR_W = TAG_W + IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqWt,
  input  logic [IDX_W-1:0]  reqIdx,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [OFF_W-1:0]  reqOff,
  input  logic [DATA_W-1:0] reqData,
  output logic              rspValid,
  output logic              rspHit,
  output logic [DATA_W-1:0] rspData,
  input  logic              lockWe,
  input  logic [IDX_W-1:0]  lockIdx,
  input  logic [1:0]        lockWays,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqData,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData
);
  ctlStrobe_t        stb;
  logic              hitW, hitWay, victimWay, bothLocked, victimDirty, rdWay;
  logic [TAG_W-1:0]  victimTag, lookTag;
  logic [IDX_W-1:0]  lookIdx;
  logic [OFF_W-1:0]  wordOff, rdOff;
  logic [DATA_W-1:0] rdData, cpuData;

  cache2w_control #(.SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqWt(reqWt), .reqIdx(reqIdx), .reqTag(reqTag),
    .reqOff(reqOff), .reqData(reqData), .rspValid(rspValid), .rspHit(rspHit),
    .rspData(rspData), .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqData(memReqData), .memRspValid(memRspValid),
    .memRspData(memRspData), .hit(hitW), .hitWay(hitWay), .victimWay(victimWay),
    .bothLocked(bothLocked), .victimDirty(victimDirty), .victimTag(victimTag),
    .rdData(rdData), .lookIdx(lookIdx), .lookTag(lookTag), .wordOff(wordOff),
    .rdWay(rdWay), .rdOff(rdOff), .cpuData(cpuData), .stb(stb)
  );

  cache2w_datapath #(.SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .lookIdx(lookIdx), .lookTag(lookTag), .wordOff(wordOff),
    .rdWay(rdWay), .rdOff(rdOff), .cpuData(cpuData), .memData(memRspData),
    .stb(stb), .lockWe(lockWe), .lockIdx(lockIdx), .lockWays(lockWays),
    .hit(hitW), .hitWay(hitWay), .victimWay(victimWay), .bothLocked(bothLocked),
    .victimDirty(victimDirty), .victimTag(victimTag), .rdData(rdData)
  );
endmodule

// File: rtl/dcache_2way_chk.sv
module dcache_2way_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic reqWrite,
  input logic reqWt,
  input logic rspValid,
  input logic rspHit,
  input logic memReqValid,
  input logic memReqWrite,
  input logic memRspValid,
  input logic hitW
);
  assert_hit_next_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && hitW && !reqWrite |=> rspValid && rspHit);

  assert_wt_store_R4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqWrite && reqWt |=> memReqValid && memReqWrite && rspValid);

  assert_wb_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqWrite && !reqWt && hitW |=> !memReqValid && rspValid);

  assert_rsp_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && reqReady) || $past(memRspValid));

  assert_busy_refill_R12: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqWrite |-> !reqReady);
endmodule

bind dcache_2way dcache_2way_chk u_chk (.*);

// File: tb/sim_dcache_2way.sv
module sim_dcache_2way;
  localparam int SETS = 4, WORDS = 4, TAG_W = 6, DATA_W = 64;
  localparam int IDX_W = 2, OFF_W = 2, ADDR_W = 10;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0, reqWt = 0, reqReady;
  logic [IDX_W-1:0] reqIdx = 0, lockIdx = 0;
  logic [TAG_W-1:0] reqTag = 0;
  logic [OFF_W-1:0] reqOff = 0;
  logic [DATA_W-1:0] reqData = 0, rspData, memReqData, memRspData = 0;
  logic rspValid, rspHit, lockWe = 0, memReqValid, memReqWrite, memRspValid = 0;
  logic [1:0] lockWays = 0;
  logic [ADDR_W-1:0] memReqAddr;

  dcache_2way u0 (.*);

  always #10 clk = ~clk;

  int errs = 0, checks = 0;
  logic [DATA_W-1:0] memArr [1 << ADDR_W];
  logic [TAG_W-1:0]  mTag  [2][SETS];
  bit                mValid[2][SETS], mDirty[2][SETS], mLock[SETS][2], mLru[SETS];
  logic [DATA_W-1:0] mData [2][SETS][WORDS];
  logic [ADDR_W-1:0] qAddr[$];
  logic [DATA_W-1:0] qData[$];
  int beatsLeft = 0, beatK = 0;
  bit armed = 0;
  logic [ADDR_W-1:0] fAddr = 0;

  task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act, exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // memory responder: one idle cycle, then WORDS beats in wrap order
  always @(negedge clk) begin
    memRspValid = 0;
    if (beatsLeft > 0) begin
      memRspValid = 1;
      memRspData  = memArr[{fAddr[ADDR_W-1:OFF_W], fAddr[OFF_W-1:0] + OFF_W'(beatK)}];
      beatK++;
      beatsLeft--;
    end else if (armed) begin
      armed = 0; beatsLeft = WORDS; beatK = 0;
    end
    if (rstN && memReqValid && !memReqWrite) begin armed = 1; fAddr = memReqAddr; end
  end

  // write monitor: every write beat against the model's queue (R4 R5 R9 R10)
  always @(negedge clk) begin
    if (rstN && memReqValid && memReqWrite) begin
      if (qAddr.size() == 0) chk(0, "R5 unexpected memory write", 64'(memReqAddr), 0);
      else begin
        logic [ADDR_W-1:0] ea; logic [DATA_W-1:0] ed;
        ea = qAddr.pop_front(); ed = qData.pop_front();
        chk(memReqAddr == ea, "R10 write beat address", 64'(memReqAddr), 64'(ea));
        chk(memReqData == ed, "R4 write beat data", memReqData, ed);
      end
    end
  end

  task automatic pushWr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    qAddr.push_back(a); qData.push_back(d); memArr[a] = d;
  endtask

  task automatic access(input bit wr, wt, input logic [TAG_W-1:0] tag,
                        input logic [IDX_W-1:0] idx, input logic [OFF_W-1:0] off,
                        input logic [DATA_W-1:0] d, input string tagName);
    bit found = 0, hb = 0, expHit, fixed, alloc = 0, v;
    logic [DATA_W-1:0] expData;
    logic [ADDR_W-1:0] a = {tag, idx, off};
    int n;
    for (int w = 0; w < 2; w++)
      if (mValid[w][idx] && mTag[w][idx] == tag) begin found = 1; hb = w[0]; end
    expHit = found;
    if (found) begin
      mLru[idx] = !hb; fixed = 1;
      if (wr) begin
        mData[hb][idx][off] = d;
        if (wt) pushWr(a, d); else mDirty[hb][idx] = 1;
      end
      expData = wr ? 0 : mData[hb][idx][off];
    end else if (wr && (wt || (mLock[idx][0] && mLock[idx][1]))) begin
      pushWr(a, d); expData = 0; fixed = 1;
    end else if (mLock[idx][0] && mLock[idx][1]) begin
      expData = memArr[a]; fixed = 0;
    end else begin
      fixed = 0; alloc = 1;
      v = mLock[idx][0] ? 1 : (mLock[idx][1] ? 0 : mLru[idx]);
      if (mValid[v][idx] && mDirty[v][idx])
        for (int k = 0; k < WORDS; k++) pushWr({mTag[v][idx], idx, OFF_W'(k)}, mData[v][idx][k]);
      for (int k = 0; k < WORDS; k++) mData[v][idx][k] = memArr[{tag, idx, OFF_W'(k)}];
      if (wr) mData[v][idx][off] = d;
      mTag[v][idx] = tag; mValid[v][idx] = 1; mDirty[v][idx] = wr; mLru[idx] = !v;
      expData = wr ? 0 : memArr[a];
    end
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqWt = wt; reqTag = tag; reqIdx = idx; reqOff = off; reqData = d;
    @(negedge clk);
    reqValid = 0; n = 1;
    while (!rspValid && n < 100) begin @(negedge clk); n++; end
    chk(rspValid, {tagName, " response seen"}, 64'(rspValid), 1);
    chk(rspHit == expHit, {tagName, " rspHit"}, 64'(rspHit), 64'(expHit));
    chk(rspData == expData, {tagName, " rspData"}, rspData, expData);
    if (fixed) chk(n == 1, {tagName, " R2 one-cycle latency"}, 64'(n), 1);
    else begin
      chk(beatK < WORDS, {tagName, " R11 critical word first"}, 64'(beatK), WORDS - 1);
      chk(!reqReady, {tagName, " R12 busy during refill"}, 64'(reqReady), 0);
    end
    while (!reqReady) @(negedge clk);
  endtask

  task automatic setLock(input logic [IDX_W-1:0] idx, input logic [1:0] ways);
    @(negedge clk);
    lockWe = 1; lockIdx = idx; lockWays = ways;
    @(negedge clk);
    lockWe = 0;
    mLock[idx][0] = ways[0]; mLock[idx][1] = ways[1];
  endtask

  initial begin
    #(200000 * 20);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) memArr[i] = {32'hC0DE_0000 + 32'(i), 32'(i * 7 + 3)};
    for (int s = 0; s < SETS; s++) begin
      mLru[s] = 0; mLock[s][0] = 0; mLock[s][1] = 0;
      for (int w = 0; w < 2; w++) begin mValid[w][s] = 0; mDirty[w][s] = 0; mTag[w][s] = 0; end
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(reqReady, "R1 reqReady after reset", 64'(reqReady), 1);
    chk(!rspValid, "R1 rspValid after reset", 64'(rspValid), 0);
    chk(!memReqValid, "R1 memReqValid after reset", 64'(memReqValid), 0);

    access(0, 0, 6'd1, 2'd0, 2'd2, 0, "R11 read miss");
    access(0, 0, 6'd1, 2'd0, 2'd0, 0, "R2 read hit");
    access(0, 0, 6'd2, 2'd0, 2'd1, 0, "R7 second way fill");
    access(0, 0, 6'd1, 2'd0, 2'd3, 0, "R3 hit way0");
    access(0, 0, 6'd1, 2'd1, 2'd3, 0, "R3 other set misses");
    access(0, 0, 6'd3, 2'd0, 2'd0, 0, "R7 evict LRU");
    access(0, 0, 6'd2, 2'd0, 2'd0, 0, "R7 evicted line misses");
    access(1, 0, 6'd2, 2'd0, 2'd2, 64'hDEAD_BEEF_0000_0001, "R5 wb store hit");
    access(0, 0, 6'd2, 2'd0, 2'd2, 0, "R5 read back");
    access(0, 0, 6'd4, 2'd0, 2'd1, 0, "R7 fill");
    access(0, 0, 6'd5, 2'd0, 2'd3, 0, "R10 dirty eviction");
    access(0, 0, 6'd2, 2'd0, 2'd2, 0, "R10 written-back data");
    access(1, 1, 6'd2, 2'd0, 2'd1, 64'h1111_2222_3333_4444, "R4 wt store hit");
    access(0, 0, 6'd2, 2'd0, 2'd1, 0, "R4 read after wt hit");
    access(1, 1, 6'd9, 2'd1, 2'd0, 64'h5555_6666_7777_8888, "R4 wt store miss");
    access(0, 0, 6'd9, 2'd1, 2'd0, 0, "R4 no allocate then read");
    access(1, 0, 6'd7, 2'd2, 2'd3, 64'hABCD_0000_1234_5678, "R6 wb store miss");
    access(0, 0, 6'd7, 2'd2, 2'd3, 0, "R6 merged word");
    access(0, 0, 6'd7, 2'd2, 2'd0, 0, "R6 refilled word");
    access(0, 0, 6'd1, 2'd3, 2'd0, 0, "R8 fill way0");
    access(0, 0, 6'd2, 2'd3, 2'd0, 0, "R8 fill way1");
    setLock(2'd3, 2'b01);
    access(0, 0, 6'd3, 2'd3, 2'd1, 0, "R8 replace unlocked");
    access(0, 0, 6'd4, 2'd3, 2'd2, 0, "R8 replace unlocked again");
    access(0, 0, 6'd1, 2'd3, 2'd0, 0, "R8 locked line kept");
    setLock(2'd3, 2'b11);
    access(0, 0, 6'd6, 2'd3, 2'd0, 0, "R9 read miss no allocate");
    access(0, 0, 6'd6, 2'd3, 2'd0, 0, "R9 still misses");
    access(1, 0, 6'd6, 2'd3, 2'd2, 64'h0F0F_0F0F_0F0F_0F0F, "R9 wb store to memory");
    access(0, 0, 6'd4, 2'd3, 2'd2, 0, "R9 locked lines kept");
    setLock(2'd3, 2'b00);
    access(0, 0, 6'd6, 2'd3, 2'd2, 0, "R8 unlocked allocates");
    repeat (10) @(negedge clk);
    chk(qAddr.size() == 0, "R10 all expected writes seen", 64'(qAddr.size()), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule